// File: doc/BRIEF.md
# Half-Precision Lane Widening Converter

This block turns packed 16-bit floating-point elements into single-precision (fp32) lanes. The source word is up to 256 bits wide. Its elements are either bf16 or IEEE binary16 (fp16), and one format input selects which. The block has three selection modes. The even mode picks elements 0, 2, 4 and so on. The odd mode picks elements 1, 3, 5 and so on. The broadcast mode takes the lowest 16-bit element and copies its widened value into every active lane.

A length input chooses between a 128-bit result with four lanes and a 256-bit result with eight lanes. Every conversion is exact and no rounding takes place. Results are registered, and a valid strobe travels with them, one clock after the request.

Top module: `hp_widen_conv`

## Requirements
- R1: `out_valid` is high exactly in the clock after a cycle in which `in_valid` was high, so latency is one clock. After reset, `out_valid` is 0 and `out_data` is all zeros.
- R2: With `in_wide`=1 the result has 8 fp32 lanes. With `in_wide`=0 only lanes 0..3 are produced and `out_data[255:128]` is zero. Lane k always sits in `out_data[32k+31:32k]`.
- R3: Mode code 0 (even) fills lane k from the element in `in_data[32k+15:32k]`. Mode code 3 behaves exactly as code 0.
- R4: Mode code 1 (odd) fills lane k from the element in `in_data[32k+31:32k+16]`.
- R5: Mode code 2 (broadcast) widens `in_data[15:0]` and places the same word in every active lane.
- R6: With `in_fmt`=0 (bf16), a lane equals the element in bits 31:16 of the lane, with bits 15:0 zero.
- R7: With `in_fmt`=1 (fp16), a normal element (exponent field 1..30) gives sign unchanged, fp32 exponent = fp16 exponent + 112, and mantissa = fp16 mantissa placed in bits 22:13 with bits 12:0 zero.
- R8: With `in_fmt`=1, an element whose exponent field is 31 gives fp32 exponent 255 with the 10 mantissa bits in bits 22:13. Infinities therefore stay infinities and a NaN keeps its payload.
- R9: With `in_fmt`=1, a zero keeps its sign (0x8000 becomes 0x80000000). A subnormal element becomes a normalised fp32 number of equal value: 0x0001 becomes 0x33800000 and 0x03FF becomes 0x387FC000.
- R10: In a cycle with `in_valid`=0, `out_data` keeps its previous value in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 256 | Packed 16-bit source elements |
| in_fmt | input | 1 | 0 = bf16, 1 = fp16 |
| in_mode | input | 2 | 0 even, 1 odd, 2 broadcast, 3 as even |
| in_wide | input | 1 | 1 = 8 lanes, 0 = 4 lanes |
| out_valid | output | 1 | Result strobe |
| out_data | output | 256 | fp32 lanes |

## Verification
Two functions can act on the same cycle. The first is lane masking by the length select. The second is lane filling by broadcast replication or by fp16 subnormal normalisation. The bench provokes the overlap with narrow-length broadcasts and with narrow odd-mode requests whose source elements are subnormal. The upper half of the source is loaded with nonzero garbage in these requests. The scoreboard passes such a request only when the lower four lanes carry the replicated or normalised word and the upper 128 bits are exactly zero. Back-to-back requests with different formats and modes then check that nothing from one request leaks into the next.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

  typedef enum logic [1:0] {
    SEL_EVEN  = 2'd0,
    SEL_ODD   = 2'd1,
    SEL_BCAST = 2'd2,
    SEL_ALT   = 2'd3
  } sel_mode_e;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  // Exact bf16 -> fp32: bf16 is the upper half of an fp32 word
  function automatic logic [31:0] widen_bf16(input logic [15:0] h);
    return {h, 16'h0000};
  endfunction

  // Index of the most significant set bit of a nonzero 10-bit mantissa
  function automatic logic [3:0] top_one(input logic [9:0] m);
    logic [3:0] p;
    p = 4'd0;
    for (int i = 0; i < 10; i++) begin
      if (m[i]) p = 4'(i);
    end
    return p;
  endfunction

  // Exact binary16 -> fp32
  function automatic logic [31:0] widen_fp16(input logic [15:0] h);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  m;
    logic [3:0]  p;
    logic [10:0] nm;
    logic [31:0] r;
    s = h[15];
    e = h[14:10];
    m = h[9:0];
    p = 4'd0;
    nm = 11'd0;
    if (e == 5'd0) begin
      if (m == 10'd0) begin
        r = {s, 31'd0};
      end else begin
        p  = top_one(m);
        nm = {1'b0, m} << (4'd10 - p);
        r  = {s, {4'd0, p} + 8'd103, nm[9:0], 13'd0};
      end
    end else if (e == 5'd31) begin
      r = {s, 8'hFF, m, 13'd0};
    end else begin
      r = {s, {3'd0, e} + 8'd112, m, 13'd0};
    end
    return r;
  endfunction

endpackage

// File: rtl/hpw_elem_pick.sv
module hpw_elem_pick
  import hpw_pkg::*;
#(
  parameter int NLANE = 8,
  parameter int EW    = 16
) (
  input  logic [NLANE*2*EW-1:0] src,
  input  logic [1:0]            mode,
  input  logic                  wide,
  output logic [NLANE*EW-1:0]   elems,
  output logic [NLANE-1:0]      active
);
  localparam int NARROW = NLANE / 2;

  logic is_bcast;
  logic is_odd;
  assign is_bcast = (mode == SEL_BCAST);
  assign is_odd   = (mode == SEL_ODD);

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [EW-1:0] lo_el, hi_el;
    assign lo_el = src[(2*k)*EW +: EW];
    assign hi_el = src[(2*k+1)*EW +: EW];
    assign elems[k*EW +: EW] = is_bcast ? src[EW-1:0] : (is_odd ? hi_el : lo_el);
    if (k < NARROW) begin : g_always
      assign active[k] = 1'b1;
    end else begin : g_upper
      assign active[k] = wide;
    end
  end
endmodule

// File: rtl/hpw_lane_cvt.sv
module hpw_lane_cvt
  import hpw_pkg::*;
(
  input  logic [15:0] elem,
  input  logic        fmt_fp16,
  input  logic        active,
  output logic [31:0] word,
  output logic        subnorm_ev,
  output logic        special_ev
);
  logic [31:0] conv;

  assign subnorm_ev = fmt_fp16 && (elem[14:10] == 5'd0) && (elem[9:0] != 10'd0);
  assign special_ev = fmt_fp16 && (elem[14:10] == 5'd31);

  always_comb begin
    if (fmt_fp16) conv = widen_fp16(elem);
    else          conv = widen_bf16(elem);
  end

  assign word = active ? conv : 32'd0;
endmodule

// File: rtl/hp_widen_conv.sv
module hp_widen_conv
  import hpw_pkg::*;
#(
  parameter int NLANE = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NLANE*32-1:0]    in_data,
  input  logic                   in_fmt,
  input  logic [1:0]             in_mode,
  input  logic                   in_wide,
  output logic                   out_valid,
  output logic [NLANE*32-1:0]    out_data
);
  localparam int DW     = NLANE * WORD_W;
  localparam int NARROW = NLANE / 2;

  logic [NLANE*HALF_W-1:0] elems;
  logic [NLANE-1:0]        active;
  logic [DW-1:0]           next_data;
  logic [NLANE-1:0]        subnorm_ev;
  logic [NLANE-1:0]        special_ev;

  hpw_elem_pick #(.NLANE(NLANE), .EW(HALF_W)) u_pick (
    .src    (in_data),
    .mode   (in_mode),
    .wide   (in_wide),
    .elems  (elems),
    .active (active)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_cvt
    hpw_lane_cvt u_cvt (
      .elem       (elems[k*HALF_W +: HALF_W]),
      .fmt_fp16   (in_fmt),
      .active     (active[k]),
      .word       (next_data[k*WORD_W +: WORD_W]),
      .subnorm_ev (subnorm_ev[k]),
      .special_ev (special_ev[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end

  // R1
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |=> (out_data[DW-1:NARROW*WORD_W] == '0));
  // R5
  bcast_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == SEL_BCAST) |=> (out_data[63:32] == out_data[31:0]));
  // R6
  bf16_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_fmt) |=> (out_data[15:0] == 16'd0));
  // R7
  fp16_rebias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt && in_mode == SEL_EVEN && in_data[14:10] != 5'd0
     && in_data[14:10] != 5'd31)
    |=> (out_data[30:23] == {3'd0, $past(in_data[14:10])} + 8'd112));
  // R8
  fp16_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && special_ev[0]) |=> (out_data[30:23] == 8'hFF));
  // R9
  fp16_subnorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && subnorm_ev[0]) |=> (out_data[30:23] != 8'd0 && out_data[30:23] < 8'd113));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
endmodule

// File: tb/sim_hp_widen_conv.sv
`timescale 1ns/1ps
module sim_hp_widen_conv;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] in_data = '0;
  logic         in_fmt = 1'b0;
  logic [1:0]   in_mode = 2'd0;
  logic         in_wide = 1'b0;
  logic         out_valid;
  logic [255:0] out_data;

  int tests = 0;
  int fails = 0;
  logic [255:0] exp_q[$];
  string        tag_q[$];
  logic [255:0] last_out = '0;

  always #10 clk = ~clk;

  hp_widen_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_fmt(in_fmt), .in_mode(in_mode), .in_wide(in_wide),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Reference: fp16 to fp32 by renormalising with a walking loop
  function automatic logic [31:0] ref_fp16(input logic [15:0] h);
    int          ex;
    logic [10:0] mm;
    if (h[14:10] == 5'h1F) return {h[15], 8'hFF, h[9:0], 13'd0};
    if (h[14:0] == 15'd0)  return {h[15], 31'd0};
    if (h[14:10] != 5'd0)  return {h[15], 8'(int'(h[14:10]) - 15 + 127), h[9:0], 13'd0};
    ex = 1;
    mm = {1'b0, h[9:0]};
    while (!mm[10]) begin
      mm = mm << 1;
      ex = ex - 1;
    end
    return {h[15], 8'(ex - 15 + 127), mm[9:0], 13'd0};
  endfunction

  function automatic logic [255:0] ref_vec(input logic [255:0] d, input logic f,
                                           input logic [1:0] md, input logic w);
    logic [255:0] r;
    logic [15:0]  e;
    r = '0;
    for (int k = 0; k < (w ? 8 : 4); k++) begin
      if (md == 2'd2)      e = d[15:0];
      else if (md == 2'd1) e = d[32*k+16 +: 16];
      else                 e = d[32*k +: 16];
      r[32*k +: 32] = f ? ref_fp16(e) : {e, 16'h0};
    end
    return r;
  endfunction

  task automatic drive(input logic [255:0] d, input logic f, input logic [1:0] md,
                       input logic w, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_fmt = f; in_mode = md; in_wide = w;
    exp_q.push_back(ref_vec(d, f, md, w));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = {8{32'hDEAD_BEEF}};
  endtask

  // Monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1: unexpected out_valid, act=1 exp=0");
        end else begin
          logic [255:0] ex;
          string t;
          ex = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_data !== ex) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", t, out_data, ex);
          end
        end
      end else begin
        // R10: idle cycle keeps data
        tests++;
        if (out_data !== last_out) begin
          fails++;
          $display("FAIL R10: act=%h exp=%h", out_data, last_out);
        end
      end
      last_out = out_data;
    end
  end

  initial begin
    logic [255:0] pat;
    logic [255:0] garbage;
    repeat (3) @(negedge clk);
    // R1 reset state
    tests++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1: reset act=%b/%h exp=0/0", out_valid, out_data);
    end
    rst_n = 1'b1;
    garbage = {8{32'hA5A5_5A5A}};
    for (int k = 0; k < 16; k++) pat[16*k +: 16] = 16'h3F80 + 16'(k);
    drive(pat, 1'b0, 2'd0, 1'b1, "R3/R6 even bf16 wide");
    drive(pat, 1'b0, 2'd1, 1'b1, "R4/R6 odd bf16 wide");
    drive(pat, 1'b0, 2'd3, 1'b1, "R3 alt code as even");
    drive({garbage[255:128], pat[127:0]}, 1'b0, 2'd1, 1'b0, "R2 odd bf16 narrow");
    pat = {16'h7BFF, 16'h3C00, 16'hC000, 16'h0400, 16'h7C00, 16'hFC00, 16'h7E01, 16'h7C01,
           16'h0001, 16'h03FF, 16'h8000, 16'h0000, 16'h8001, 16'h0200, 16'h3555, 16'hB800};
    drive(pat, 1'b1, 2'd0, 1'b1, "R7/R8/R9 even fp16");
    drive(pat, 1'b1, 2'd1, 1'b1, "R7/R8/R9 odd fp16");
    drive({garbage[255:128], pat[127:0]}, 1'b1, 2'd1, 1'b0, "R2/R9 odd fp16 subnormal narrow");
    drive({garbage[255:16], 16'h0001}, 1'b1, 2'd2, 1'b0, "R5/R2 bcast fp16 narrow");
    drive({garbage[255:16], 16'h7E01}, 1'b1, 2'd2, 1'b1, "R5/R8 bcast fp16 NaN wide");
    drive({garbage[255:16], 16'hC0A0}, 1'b0, 2'd2, 1'b1, "R5/R6 bcast bf16 wide");
    drive({garbage[255:16], 16'h8000}, 1'b1, 2'd2, 1'b1, "R9 bcast negative zero");
    // back-to-back random requests
    for (int n = 0; n < 40; n++) begin
      logic [255:0] r;
      for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom;
      @(negedge clk);
      in_valid = 1'b1; in_data = r; in_fmt = 1'(n);
      in_mode = 2'(n / 2); in_wide = 1'(n / 3);
      exp_q.push_back(ref_vec(r, in_fmt, in_mode, in_wide));
      tag_q.push_back("R1-mix random back-to-back");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: missing results act=%0d exp=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule